// File: doc/BRIEF.md
# Serial TDM Input Bit-Delay Aligner

This block takes one serial time-division-multiplexed input line and turns it into a sequence of 8-bit channel bytes. The line runs at one of two data rates: 16.384 Mb/s, with 256 channels per 125 us frame, or 32.768 Mb/s, with 512 channels per frame. The block runs entirely on a 65.536 MHz sampling tick. One bit lasts four ticks at the lower rate and two ticks at the higher rate. Each frame is therefore 8192 ticks long, and it starts at the tick in which the frame pulse is high.

Skew on the board can place the serial data late relative to the frame pulse. To compensate, the block measures a delayed position from the frame boundary. That position is the tick number minus a programmable delay code, and one code step is one tick. One tick is a quarter bit at the lower rate and half a bit at the higher rate. Each bit is sampled at the middle tick of its delayed window. Bits arrive most significant first. When the last bit of a byte has been sampled, the block presents the byte, its channel number and a one-cycle valid strobe.

A small write port sets the delay code and the rate. Both settings are held as pending values and are applied together at the next frame pulse, so a frame already in progress is never disturbed. The frame pulse and all inputs are synchronous to the sampling tick. The 8.192 MHz reference clock is not an input, because its edges coincide with every eighth tick.

Top module: `tdm_bit_aligner`

## Requirements
- R1: After reset `valid_o`, `byte_o` and `chan_o` are all zero, and `valid_o` stays low until the first frame pulse has been seen.
- R2: Frame tick 0 is the cycle in which `fp_i` is high. The delayed position is (tick − active delay) modulo the frame length. At the low rate, bit k covers positions 4k..4k+3 and is sampled at position 4k+2. At the high rate, bit k covers positions 2k..2k+1 and is sampled at position 2k+1.
- R3: The first bit of a frame is bit 7 of channel 0. Bits of a byte arrive most significant first, and `byte_o` holds the eight samples of one channel in that order.
- R4: `valid_o` is high for exactly the cycle after the sample of a byte's bit 0. In that cycle `chan_o` gives the channel: 0..N/2−1 at the low rate and 0..N−1 at the high rate, where N = 2^CH_W.
- R5: At the low rate the delay code is taken as is: 0..31 ticks, which is 0 to 7 3/4 bits in quarter-bit steps.
- R6: At the high rate a code above 15 is applied as 15, giving at most 7 1/2 bits in half-bit steps. The stored pending code keeps its raw value.
- R7: A write with `cfg_addr_i`=0 sets the pending delay from `cfg_wdata_i[4:0]`. A write with `cfg_addr_i`=1 sets the pending rate from `cfg_wdata_i[0]` (0 = 16.384 Mb/s, 1 = 32.768 Mb/s). Pending values become active only at a frame pulse, and a write in the same cycle as the frame pulse is applied at that pulse.
- R8: The last channel's bits that fall past the frame end, because of the delay, are sampled in the first ticks of the next frame. That channel's byte is delivered there with the data of the frame it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 65.536 MHz sampling tick |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, one tick wide, marks frame tick 0 |
| sdat_i | input | 1 | Serial TDM data |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 selects delay code, 1 selects rate |
| cfg_wdata_i | input | DLY_W | Write data |
| byte_o | output | 8 | Recovered channel byte |
| chan_o | output | CH_W | Channel number of `byte_o` |
| valid_o | output | 1 | One-cycle strobe for a new byte |

## Verification
A configuration write and the frame pulse can land in the same cycle. In that case the new delay or rate must already govern the sampling position of that very tick. The bench provokes this by issuing the delay write in the frame-pulse cycle for every odd code at both rates. For every even code, it writes mid-frame instead and expects the old delay to hold until the pulse. The bench drives the inverse of the wanted bit on every non-middle tick of each bit window, so an early or late application of the delay shows up as corrupted bytes and shifted strobes, and these are judged against an arithmetic model.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;

  typedef enum logic {
    RATE_LO = 1'b0,
    RATE_HI = 1'b1
  } rate_e;

  localparam logic CFG_ADDR_DLY  = 1'b0;
  localparam logic CFG_ADDR_RATE = 1'b1;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned BIT_IDX_W = 3;

endpackage

// File: rtl/tdm_align_cfg.sv
module tdm_align_cfg
  import tdm_align_pkg::*;
#(
  parameter int unsigned DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [DLY_W-1:0] wdata_i,
  input  logic             frame_start_i,
  output logic [DLY_W-1:0] dly_cur_o,
  output rate_e            rate_cur_o,
  output logic [DLY_W-1:0] dly_q_o,
  output rate_e            rate_q_o
);

  // Largest code usable at the high rate: half the code range.
  localparam logic [DLY_W-1:0] HI_MAX = {1'b0, {(DLY_W-1){1'b1}}};

  logic [DLY_W-1:0] pend_dly_q, pend_dly_d;
  rate_e            pend_rate_q, pend_rate_d;
  logic [DLY_W-1:0] act_dly_q, act_dly_d;
  rate_e            act_rate_q, act_rate_d;
  logic [DLY_W-1:0] pend_sat;
  logic             pend_en, act_en;

  // Pending settings, with a same-cycle write visible to the apply path.
  always_comb begin
    pend_dly_d  = pend_dly_q;
    pend_rate_d = pend_rate_q;
    if (wr_i) begin
      if (addr_i == CFG_ADDR_RATE) begin
        pend_rate_d = rate_e'(wdata_i[0]);
      end else begin
        pend_dly_d = wdata_i;
      end
    end
  end

  assign pend_en = wr_i;

  // Saturation is decided against the rate being applied together with it.
  always_comb begin
    pend_sat = pend_dly_d;
    if ((pend_rate_d == RATE_HI) && (pend_dly_d > HI_MAX)) begin
      pend_sat = HI_MAX;
    end
  end

  always_comb begin
    act_dly_d  = act_dly_q;
    act_rate_d = act_rate_q;
    if (frame_start_i) begin
      act_dly_d  = pend_sat;
      act_rate_d = pend_rate_d;
    end
  end

  assign act_en = frame_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_dly_q  <= '0;
      pend_rate_q <= RATE_LO;
      act_dly_q   <= '0;
      act_rate_q  <= RATE_LO;
    end else begin
      if (pend_en) begin
        pend_dly_q  <= pend_dly_d;
        pend_rate_q <= pend_rate_d;
      end
      if (act_en) begin
        act_dly_q  <= act_dly_d;
        act_rate_q <= act_rate_d;
      end
    end
  end

  // Values governing the current tick (new values already in the pulse tick).
  assign dly_cur_o  = act_dly_d;
  assign rate_cur_o = act_rate_d;
  assign dly_q_o    = act_dly_q;
  assign rate_q_o   = act_rate_q;

endmodule

// File: rtl/tdm_align_pos.sv
module tdm_align_pos #(
  parameter int unsigned PW    = 13,
  parameter int unsigned DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [DLY_W-1:0] dly_cur_i,
  output logic [PW-1:0]    pos_o,
  output logic             locked_o
);

  logic [PW-1:0] pos_q, pos_d, pos_start;
  logic          locked_q, locked_d;

  // A frame pulse places the delayed position at minus the delay, so the
  // sampling grid trails the frame boundary by that many ticks.
  assign pos_start = {PW{1'b0}} - {{(PW-DLY_W){1'b0}}, dly_cur_i};

  always_comb begin
    pos_o    = frame_start_i ? pos_start : pos_q;
    pos_d    = pos_o + 1'b1;
    locked_d = locked_q | frame_start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      pos_q    <= pos_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_d;

endmodule

// File: rtl/tdm_align_sampler.sv
module tdm_align_sampler
  import tdm_align_pkg::*;
#(
  parameter int unsigned PW   = 13,
  parameter int unsigned CH_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PW-1:0]     pos_i,
  input  rate_e             rate_i,
  input  logic              locked_i,
  input  logic              sdat_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              valid_o
);

  localparam int unsigned NRATE = 2;

  logic [NRATE-1:0] smp_v;
  logic [NRATE-1:0] last_v;
  logic [CH_W-1:0]  chan_v [NRATE];

  // One position decoder per rate; index 0 is the low rate.
  for (genvar g = 0; g < NRATE; g++) begin : g_rate
    localparam int unsigned TB    = (g == 0) ? 2 : 1;
    localparam int unsigned CB    = PW - TB - BIT_IDX_W;
    localparam int unsigned MID_I = 1 << (TB - 1);

    logic [TB-1:0]        phase;
    logic [BIT_IDX_W-1:0] bnum;
    logic [CB-1:0]        ch;

    assign phase     = pos_i[TB-1:0];
    assign bnum      = pos_i[TB+BIT_IDX_W-1:TB];
    assign ch        = pos_i[PW-1:TB+BIT_IDX_W];
    assign smp_v[g]  = (phase == MID_I[TB-1:0]);
    assign last_v[g] = smp_v[g] && (bnum == {BIT_IDX_W{1'b1}});
    assign chan_v[g] = CH_W'(ch);
  end

  logic              rsel;
  logic              smp, last;
  logic [CH_W-1:0]   chan_sel;
  logic [BYTE_W-2:0] sh_q, sh_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              valid_q, valid_d;
  logic              sh_en, cap_en;

  assign rsel     = (rate_i == RATE_HI);
  assign smp      = smp_v[rsel];
  assign last     = last_v[rsel];
  assign chan_sel = chan_v[rsel];

  always_comb begin
    sh_en   = smp;
    cap_en  = last && locked_i;
    sh_d    = {sh_q[BYTE_W-3:0], sdat_i};
    byte_d  = {sh_q, sdat_i};
    chan_d  = chan_sel;
    valid_d = cap_en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      byte_q  <= '0;
      chan_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (sh_en) begin
        sh_q <= sh_d;
      end
      if (cap_en) begin
        byte_q <= byte_d;
        chan_q <= chan_d;
      end
      valid_q <= valid_d;
    end
  end

  assign byte_o  = byte_q;
  assign chan_o  = chan_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/tdm_bit_aligner.sv
module tdm_bit_aligner
  import tdm_align_pkg::*;
#(
  parameter int unsigned CH_W  = 9,
  parameter int unsigned DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic             sdat_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_addr_i,
  input  logic [DLY_W-1:0] cfg_wdata_i,
  output logic [7:0]       byte_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             valid_o
);

  // Frame = 2^CH_W channels x 8 bits x 2 ticks at the high rate.
  localparam int unsigned PW = CH_W + 4;

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic [DLY_W-1:0] dly_cur, act_dly_q;
  rate_e            rate_cur, act_rate_q;
  logic [PW-1:0]    pos;
  logic             locked;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  tdm_align_cfg #(
    .DLY_W (DLY_W)
  ) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .wr_i          (cfg_wr_i),
    .addr_i        (cfg_addr_i),
    .wdata_i       (cfg_wdata_i),
    .frame_start_i (fp_i),
    .dly_cur_o     (dly_cur),
    .rate_cur_o    (rate_cur),
    .dly_q_o       (act_dly_q),
    .rate_q_o      (act_rate_q)
  );

  tdm_align_pos #(
    .PW    (PW),
    .DLY_W (DLY_W)
  ) u_pos (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .frame_start_i (fp_i),
    .dly_cur_i     (dly_cur),
    .pos_o         (pos),
    .locked_o      (locked)
  );

  tdm_align_sampler #(
    .PW   (PW),
    .CH_W (CH_W)
  ) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .pos_i    (pos),
    .rate_i   (rate_cur),
    .locked_i (locked),
    .sdat_i   (sdat_i),
    .byte_o   (byte_o),
    .chan_o   (chan_o),
    .valid_o  (valid_o)
  );

endmodule

// File: rtl/tdm_bit_aligner_chk.sv
module tdm_bit_aligner_chk
  import tdm_align_pkg::*;
#(
  parameter int unsigned DLY_W = 5
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             fp_i,
  input logic             valid_o,
  input logic             chan_msb,
  input logic [DLY_W-1:0] act_dly,
  input rate_e            act_rate
);

  localparam logic [DLY_W-1:0] HI_MAX = {1'b0, {(DLY_W-1){1'b1}}};

  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (fp_i) begin
      seen_q <= 1'b1;
    end
  end

  AST_IDLE_BEFORE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_n)
    !seen_q |-> !valid_o) else $error("strobe before first frame pulse"); // R1

  AST_CFG_HELD_MIDFRAME: assert property (@(posedge clk_i) disable iff (!rst_n)
    !fp_i |=> ($stable(act_dly) && $stable(act_rate))) else $error("active setting moved mid-frame"); // R7

  AST_HI_RATE_SATURATED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (act_rate == RATE_HI) |-> (act_dly <= HI_MAX)) else $error("delay above high-rate limit"); // R6

  AST_LO_RATE_CHAN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (valid_o && (act_rate == RATE_LO)) |-> !chan_msb) else $error("channel out of low-rate range"); // R4

endmodule

bind tdm_bit_aligner tdm_bit_aligner_chk #(
  .DLY_W (DLY_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .fp_i     (fp_i),
  .valid_o  (valid_o),
  .chan_msb (chan_o[CH_W-1]),
  .act_dly  (act_dly_q),
  .act_rate (act_rate_q)
);

// File: tb/tdm_bit_aligner_tb.sv
`timescale 1ns/1ps
module tdm_bit_aligner_tb;

  localparam int CH_W  = 4;
  localparam int DLY_W = 5;
  localparam int PW    = CH_W + 4;
  localparam int FT    = 1 << PW;

  logic             clk = 1'b0;
  logic             rst_ni;
  logic             fp_i;
  logic             sdat_i;
  logic             cfg_wr_i;
  logic             cfg_addr_i;
  logic [DLY_W-1:0] cfg_wdata_i;
  logic [7:0]       byte_o;
  logic [CH_W-1:0]  chan_o;
  logic             valid_o;

  always #2 clk = ~clk;

  tdm_bit_aligner #(.CH_W(CH_W), .DLY_W(DLY_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fp_i(fp_i), .sdat_i(sdat_i),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .byte_o(byte_o), .chan_o(chan_o), .valid_o(valid_o)
  );

  int checks = 0;
  int errors = 0;

  // Arithmetic model state
  int    t = 0;
  bit    started = 0;
  bit    locked = 0;
  bit    changed = 0;
  int    act_d = 0, pend_d = 0;
  bit    act_r = 0, pend_r = 0;
  int    seed_cur = 0, seed_prev = 0;
  int    prelock_hits = 0;
  string tag = "R2";

  logic            e_valid = 1'b0;
  logic [CH_W-1:0] e_chan = '0;
  logic [7:0]      e_byte = '0;
  bit              e_skip = 0, e_last = 0;
  int              t_prev = 0;

  function automatic logic [7:0] byte_of(int ch, int seed);
    return 8'((ch * 29 + seed * 53 + 11) & 255);
  endfunction

  task automatic step(input bit wr, input bit a, input int wd);
    int bt, pos, bidx, ch, bpos, ph, sseed, new_d;
    bit fp, sdv;
    logic [7:0] bv;
    @(negedge clk);
    if (e_valid || valid_o) begin
      checks++;
      if (valid_o !== e_valid) begin
        errors++;
        $display("FAIL R4 R2 %s: valid_o=%0b expected %0b (tick %0d)", tag, valid_o, e_valid, t_prev);
      end else begin
        checks++;
        if (chan_o !== e_chan) begin
          errors++;
          $display("FAIL R4 %s: chan_o=%0d expected %0d (tick %0d)", tag, chan_o, e_chan, t_prev);
        end
        if (!e_skip) begin
          checks++;
          if (byte_o !== e_byte) begin
            errors++;
            $display("FAIL R2 R3 %s%s: byte_o=%02h expected %02h ch %0d (tick %0d)",
                     tag, e_last ? " R8" : "", byte_o, e_byte, e_chan, t_prev);
          end
        end
      end
    end
    if (!locked && valid_o) prelock_hits++;

    fp = started && (t == 0);
    if (wr) begin
      if (a) pend_r = wd[0];
      else   pend_d = wd;
    end
    if (fp) begin
      new_d     = (pend_r && pend_d > 15) ? 15 : pend_d;
      changed   = !locked || (new_d != act_d) || (pend_r != act_r);
      act_d     = new_d;
      act_r     = pend_r;
      locked    = 1;
      seed_prev = seed_cur;
      seed_cur++;
    end
    bt    = act_r ? 2 : 4;
    pos   = (t + FT - act_d) % FT;
    sseed = (t < act_d) ? seed_prev : seed_cur;
    bidx  = pos / bt;
    ch    = bidx / 8;
    bpos  = 7 - (bidx % 8);
    ph    = pos % bt;
    bv    = byte_of(ch, sseed);
    sdv   = bv[bpos] ^ (ph != bt / 2);

    e_valid = locked && (ph == bt / 2) && (bpos == 0);
    e_chan  = CH_W'(ch);
    e_byte  = bv;
    e_skip  = changed && (t < 48);
    e_last  = (ch == FT / (bt * 8) - 1);
    t_prev  = t;

    fp_i        = fp;
    sdat_i      = started ? sdv : t_prev[0] ^ pos[1];
    cfg_wr_i    = wr;
    cfg_addr_i  = a;
    cfg_wdata_i = wd[DLY_W-1:0];
    if (started) t = (t + 1) % FT;
  endtask

  task automatic run_to(input int tt);
    while (t != tt) step(0, 0, 0);
  endtask

  initial begin
    rst_ni = 1'b0; fp_i = 1'b0; sdat_i = 1'b0;
    cfg_wr_i = 1'b0; cfg_addr_i = 1'b0; cfg_wdata_i = '0;
    repeat (4) @(negedge clk);
    checks++; if (valid_o !== 1'b0) begin errors++; $display("FAIL R1: reset valid_o=%0b expected 0", valid_o); end
    checks++; if (byte_o !== 8'h00) begin errors++; $display("FAIL R1: reset byte_o=%02h expected 00", byte_o); end
    checks++; if (chan_o !== '0) begin errors++; $display("FAIL R1: reset chan_o=%0d expected 0", chan_o); end
    rst_ni = 1'b1;
    repeat (80) step(0, 0, 0);
    checks++;
    if (prelock_hits != 0) begin
      errors++; $display("FAIL R1: %0d strobes before first frame pulse, expected 0", prelock_hits);
    end
    started = 1;
    for (int r = 0; r < 2; r++) begin
      for (int c = 0; c < 32; c++) begin
        tag = (r == 1) ? "R6 R7" : "R5 R7";
        run_to(100);
        step(1, 1, r);
        if (c % 2 == 0) begin
          step(1, 0, c);
          run_to(0);
          repeat (2 * FT) step(0, 0, 0);
        end else begin
          run_to(0);
          step(1, 0, c);
          repeat (2 * FT - 1) step(0, 0, 0);
        end
      end
    end
    step(0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run still active after 200000 cycles, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule